// File: doc/BRIEF.md
# Prescaled Sleep Timer

This block keeps system time in a 32-bit counter that runs freely and advances on divided ticks from one of two low-frequency tick sources: a 1 kHz reference tick, which is the default, or a 32.768 kHz crystal tick. The source tick arrives as a one-cycle enable in the block's clock domain. A power-of-two prescaler sits between the selected tick and the counter, so a single counter step can stand for anywhere from one to 32768 source ticks.

Two compare channels and a wrap detector watch the counter. Each of them sets a sticky flag. Software clears a flag by writing a one to it. A combined wake output is raised while any flag is set whose enable bit is on. A debug-halt input freezes the prescaler and the counter, and no configuration bit is needed for this. When no source tick arrives, the counter does not move and no event occurs.

The register port uses word addresses. A write is a single-cycle strobe, and reads are combinational.

Top module: `slp_timer`

## Requirements
- R1: After reset, every register reads zero, and `irq_flags_o` and `wake_o` are low. The registers are: configuration at address 0, count at 1, compare 0 at 2, compare 1 at 3, flags at 4 and wake enable at 5. Any other address reads zero.
- R2: The count advances by exactly one on each prescaled tick. Without a prescaled tick it holds its value.
- R3: Configuration bit 0 selects the tick source: 0 selects `tick_ref_i` and 1 selects `tick_xtal_i`. Ticks on the source that is not selected have no effect.
- R4: Configuration bits [7:4] hold the exponent N. The count advances once every 2^N ticks of the selected source.
- R5: A configuration write that changes the source select or N clears the prescaler. The tick count toward the next step then starts again from zero.
- R6: While `dbg_halt_i` is high, source ticks are ignored, and both the prescaler and the count hold their values.
- R7: Flag bit 0 (compare 0) or bit 1 (compare 1) is set on the prescaled tick that makes the count equal to that channel's compare value. The flag is set once per such step.
- R8: Flag bit 2 is set on the prescaled tick that takes the count from all-ones to zero.
- R9: Flags are sticky. Writing a one to a flag bit clears that flag, and writing a zero leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R10: `irq_flags_o` shows the raw flags. `wake_o` is the OR of the flags ANDed with the wake-enable bits, which use the same bit positions.
- R11: A write to the count register loads the count and takes priority over a tick in the same cycle. A load raises no compare or wrap event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ref_i | input | 1 | One-cycle 1 kHz reference tick |
| tick_xtal_i | input | 1 | One-cycle 32.768 kHz crystal tick |
| dbg_halt_i | input | 1 | Debugger halt; freezes timing |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_flags_o | output | 3 | Sticky event flags (compare 0, compare 1, wrap) |
| wake_o | output | 1 | Combined masked wake request |

## Verification
A prescaler phase that is wrong stays hidden at first. It shows up only at the next counter step, which can come up to 2^N source ticks later. For that reason the bench changes N in the middle of a count and checks the very next step. A wrong count or compare value shows up as a missing or doubled flag on the step that matches. A wrong flag state reaches `irq_flags_o` and `wake_o` one cycle after the tick that caused it. The bench compares its reference model against every output on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_CMP = 2;
  localparam int NUM_EV  = NUM_CMP + 1;
  localparam int EV_WRAP = NUM_CMP;
  localparam int CFG_EXP_LSB = 4;

  localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAGS = A_CMP0 + ADDR_W'(NUM_CMP);
  localparam logic [ADDR_W-1:0] A_WEN   = A_FLAGS + 3'd1;
endpackage

// File: rtl/slp_prescaler.sv
module slp_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             restart_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             stb_o
);
  localparam int PW = (1 << EXP_W) - 1;

  logic [PW-1:0] pcnt_q, pcnt_d, mask;
  logic          adv;

  always_comb begin
    for (int b = 0; b < PW; b++) mask[b] = (b < int'(exp_i));
  end

  assign adv   = tick_i && !hold_i && !restart_i;
  assign stb_o = adv && ((pcnt_q & mask) == mask);

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart_i)  pcnt_d = '0;
    else if (adv)   pcnt_d = stb_o ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  a_r6_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !restart_i) |=> $stable(pcnt_q));
  a_r4_within_period: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt_q & ~mask) == '0);
endmodule

// File: rtl/slp_core.sv
module slp_core #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_i [NUM_CMP],
  output logic [CNT_W-1:0] cnt_o,
  output logic [NUM_CMP:0] ev_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             step;

  assign cnt_inc = cnt_q + 1'b1;
  assign step    = stb_i && !load_i;

  generate
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      assign ev_o[g] = step && (cnt_inc == cmp_i[g]);
      a_r7_match_value: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o[g] |=> cnt_q == $past(cmp_i[g]));
    end
  endgenerate
  assign ev_o[NUM_CMP] = step && (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (stb_i) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_i && !load_i) |=> $stable(cnt_q));
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o[NUM_CMP] |=> cnt_q == '0);
endmodule

// File: rtl/slp_flags.sv
module slp_flags #(
  parameter int N_EV = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] set_i,
  input  logic [N_EV-1:0] clr_i,
  input  logic [N_EV-1:0] en_i,
  output logic [N_EV-1:0] flags_o,
  output logic            wake_o
);
  logic [N_EV-1:0] flags_q, flags_d;

  assign flags_d = (flags_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign wake_o  = |(flags_q & en_i);

  generate
    for (genvar i = 0; i < N_EV; i++) begin : g_chk
      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[i] && !clr_i[i]) |=> flags_q[i]);
      a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> flags_q[i]);
    end
  endgenerate
endmodule

// File: rtl/slp_timer.sv
module slp_timer
  import slp_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int EXP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ref_i,
  input  logic              tick_xtal_i,
  input  logic              dbg_halt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NUM_EV-1:0] irq_flags_o,
  output logic              wake_o
);
  logic rs1_q, rs2_q, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s = rs2_q;

  logic               sel_q, sel_d;
  logic [EXP_W-1:0]   exp_q, exp_d;
  logic [CNT_W-1:0]   cmp_q [NUM_CMP];
  logic [CNT_W-1:0]   cmp_d [NUM_CMP];
  logic [NUM_EV-1:0]  wen_q, wen_d;
  logic               wr_cfg, wr_cnt, wr_flg, wr_wen, restart, tick_sel, stb;
  logic [NUM_EV-1:0]  ev, clr, flags;
  logic [CNT_W-1:0]   cnt;

  assign wr_cfg  = wr_en_i && (addr_i == A_CFG);
  assign wr_cnt  = wr_en_i && (addr_i == A_COUNT);
  assign wr_flg  = wr_en_i && (addr_i == A_FLAGS);
  assign wr_wen  = wr_en_i && (addr_i == A_WEN);
  assign restart = wr_cfg &&
    ({wdata_i[CFG_EXP_LSB +: EXP_W], wdata_i[0]} != {exp_q, sel_q});
  assign clr      = wr_flg ? wdata_i[NUM_EV-1:0] : '0;
  assign tick_sel = sel_q ? tick_xtal_i : tick_ref_i;

  always_comb begin
    sel_d = sel_q;
    exp_d = exp_q;
    wen_d = wen_q;
    if (wr_cfg) begin
      sel_d = wdata_i[0];
      exp_d = wdata_i[CFG_EXP_LSB +: EXP_W];
    end
    if (wr_wen) wen_d = wdata_i[NUM_EV-1:0];
    for (int i = 0; i < NUM_CMP; i++) begin
      cmp_d[i] = cmp_q[i];
      if (wr_en_i && (addr_i == A_CMP0 + ADDR_W'(i))) cmp_d[i] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      sel_q <= 1'b0;
      exp_q <= '0;
      wen_q <= '0;
      for (int i = 0; i < NUM_CMP; i++) cmp_q[i] <= '0;
    end else begin
      sel_q <= sel_d;
      exp_q <= exp_d;
      wen_q <= wen_d;
      for (int i = 0; i < NUM_CMP; i++) cmp_q[i] <= cmp_d[i];
    end
  end

  slp_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk(clk), .rst_n(rst_s), .tick_i(tick_sel), .hold_i(dbg_halt_i),
    .restart_i(restart), .exp_i(exp_q), .stb_o(stb)
  );

  slp_core #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_core (
    .clk(clk), .rst_n(rst_s), .stb_i(stb), .load_i(wr_cnt),
    .load_val_i(wdata_i), .cmp_i(cmp_q), .cnt_o(cnt), .ev_o(ev)
  );

  slp_flags #(.N_EV(NUM_EV)) u_flags (
    .clk(clk), .rst_n(rst_s), .set_i(ev), .clr_i(clr), .en_i(wen_q),
    .flags_o(flags), .wake_o(wake_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CFG) begin
      rdata_o[0] = sel_q;
      rdata_o[CFG_EXP_LSB +: EXP_W] = exp_q;
    end else if (addr_i == A_COUNT) rdata_o = cnt;
    else if (addr_i == A_FLAGS)     rdata_o[NUM_EV-1:0] = flags;
    else if (addr_i == A_WEN)       rdata_o[NUM_EV-1:0] = wen_q;
    for (int i = 0; i < NUM_CMP; i++)
      if (addr_i == A_CMP0 + ADDR_W'(i)) rdata_o = cmp_q[i];
  end

  assign irq_flags_o = flags;

  a_r11_load_value: assert property (@(posedge clk) disable iff (!rst_s)
    wr_cnt |=> cnt == $past(wdata_i));
  a_r11_load_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    wr_cnt |-> ev == '0);
  a_r6_halt_count: assert property (@(posedge clk) disable iff (!rst_s)
    (dbg_halt_i && !wr_cnt) |=> $stable(cnt));
endmodule

// File: tb/slp_timer_test.sv
`timescale 1ns/1ps
module slp_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_ref = 1'b0, tick_xtal = 1'b0, halt = 1'b0, wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  logic        wake;
  int checks = 0, fails = 0, cyc = 0;
  bit live = 1'b0;

  always #2 clk = ~clk;

  slp_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_ref_i(tick_ref), .tick_xtal_i(tick_xtal),
    .dbg_halt_i(halt), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_flags_o(irq), .wake_o(wake)
  );

  // behavioural reference state
  bit          m_sel;
  int          m_n, m_pc;
  logic [31:0] m_cnt, m_cmp0, m_cmp1;
  logic [2:0]  m_flg, m_wen;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {24'd0, 4'(m_n), 3'd0, m_sel};
      3'd1: return m_cnt;
      3'd2: return m_cmp0;
      3'd3: return m_cmp1;
      3'd4: return {29'd0, m_flg};
      3'd5: return {29'd0, m_wen};
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit restart, act, pre, load;
    logic [2:0] ev, clr;
    if (!rst_n) begin
      m_sel = 0; m_n = 0; m_pc = 0; m_cnt = 0; m_cmp0 = 0; m_cmp1 = 0;
      m_flg = 0; m_wen = 0;
    end else begin
      restart = wr && addr == 3'd0 && (wdata[0] != m_sel || int'(wdata[7:4]) != m_n);
      act  = (m_sel ? tick_xtal : tick_ref) && !halt;
      load = wr && addr == 3'd1;
      pre  = 0;
      if (restart) m_pc = 0;
      else if (act) begin
        if (m_pc == (1 << m_n) - 1) begin m_pc = 0; pre = 1; end
        else m_pc++;
      end
      ev = '0;
      if (pre && !load) begin
        ev[0] = (m_cnt + 32'd1 == m_cmp0);
        ev[1] = (m_cnt + 32'd1 == m_cmp1);
        ev[2] = (m_cnt == 32'hFFFF_FFFF);
      end
      clr = (wr && addr == 3'd4) ? wdata[2:0] : 3'd0;
      m_flg = (m_flg & ~clr) | ev;
      if (load) m_cnt = wdata;
      else if (pre) m_cnt = m_cnt + 32'd1;
      if (wr && addr == 3'd0) begin m_sel = wdata[0]; m_n = int'(wdata[7:4]); end
      if (wr && addr == 3'd2) m_cmp0 = wdata;
      if (wr && addr == 3'd3) m_cmp1 = wdata;
      if (wr && addr == 3'd5) m_wen = wdata[2:0];
    end
    #1;
    if (live) begin
      chk(irq == m_flg, "R10 model flags", {29'd0, irq}, {29'd0, m_flg});
      chk(wake == |(m_flg & m_wen), "R10 model wake", {31'd0, wake}, {31'd0, |(m_flg & m_wen)});
      chk(rdata == m_read(addr), "R2 model read", rdata, m_read(addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); addr = a; #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic tref(int n);
    repeat (n) begin @(negedge clk); tick_ref = 1; @(negedge clk); tick_ref = 0; end
  endtask

  task automatic txtal(int n);
    repeat (n) begin @(negedge clk); tick_xtal = 1; @(negedge clk); tick_xtal = 0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    live = 1;
    rd(3'd0, 0, "R1 cfg");   rd(3'd1, 0, "R1 count");
    rd(3'd4, 0, "R1 flags"); rd(3'd5, 0, "R1 wen"); rd(3'd7, 0, "R1 unmapped");
    chk(wake == 0, "R1 wake", {31'd0, wake}, 0);
    wreg(3'd2, 1000); wreg(3'd3, 2000);
    tref(5);  rd(3'd1, 5, "R2 ref count");
    txtal(5); rd(3'd1, 5, "R3 xtal ignored");
    wreg(3'd0, 32'h21);
    txtal(8); rd(3'd1, 7, "R4 divide by 4");
    tref(4);  rd(3'd1, 7, "R3 ref ignored");
    txtal(3); wreg(3'd0, 32'h11);
    txtal(1); rd(3'd1, 7, "R5 prescaler cleared");
    txtal(1); rd(3'd1, 8, "R5 step after restart");
    @(negedge clk); halt = 1;
    txtal(4);
    @(negedge clk); halt = 0;
    rd(3'd1, 8, "R6 halt freeze");
    txtal(2); rd(3'd1, 9, "R6 resume");
    wreg(3'd0, 0); wreg(3'd2, 11);
    tref(2); rd(3'd4, 1, "R7 cmp0 match");
    tref(1); rd(3'd4, 1, "R7 sticky");
    wreg(3'd4, 1);
    tref(3); rd(3'd4, 0, "R7 once only");
    wreg(3'd3, 17);
    tref(2); rd(3'd4, 2, "R7 cmp1 match");
    wreg(3'd4, 1); rd(3'd4, 2, "R9 zero keeps");
    wreg(3'd4, 2); rd(3'd4, 0, "R9 w1c");
    wreg(3'd1, 10); rd(3'd1, 10, "R11 load");
    wreg(3'd1, 11); rd(3'd4, 0, "R11 load no event");
    @(negedge clk); wr = 1; addr = 3'd1; wdata = 50; tick_ref = 1;
    @(negedge clk); wr = 0; tick_ref = 0;
    rd(3'd1, 50, "R11 load beats tick");
    wreg(3'd1, 32'hFFFF_FFFE);
    tref(1); rd(3'd4, 0, "R8 no wrap yet");
    tref(1); rd(3'd1, 0, "R8 count zero");
    rd(3'd4, 4, "R8 wrap flag");
    chk(wake == 0, "R10 masked", {31'd0, wake}, 0);
    wreg(3'd5, 4); #1 chk(wake == 1, "R10 enabled", {31'd0, wake}, 1);
    wreg(3'd5, 3); #1 chk(wake == 0, "R10 other mask", {31'd0, wake}, 0);
    wreg(3'd5, 4); wreg(3'd4, 4);
    #1 chk(wake == 0, "R10 cleared", {31'd0, wake}, 0);
    wreg(3'd2, 1); tref(1); wreg(3'd2, 2);
    @(negedge clk); wr = 1; addr = 3'd4; wdata = 1; tick_ref = 1;
    @(negedge clk); wr = 0; tick_ref = 0;
    rd(3'd4, 1, "R9 set wins");
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule